// File: doc/BRIEF.md
# Edge-Triggered Tri-State Phase Detector

This block compares the timing of two square waves, a reference signal and a feedback comparator, using a fast system clock. It looks only at the rising edges of each wave. When one wave's rising edge arrives before the other's, the block drives a charge output. It drives high when the reference leads and low when the feedback leads. It stops driving when the lagging edge arrives. A loop filter and oscillator outside the block turn this into a frequency correction. Because of that, a locked loop sees a released output almost all of the time.

The charge output has three states and is split into a drive value and an active-high output enable. A third output, the phase-lock flag, is high whenever the output is released, so it can serve as a lock indicator. Both inputs are asynchronous. Each one passes through a synchronizer chain, `SYNC_STAGES` flops deep with a default of 2. A registered edge detector then turns each rising edge into a single-cycle event.

The controller has three states:
- `ST_FLOAT`: released.
- `ST_PUMP_UP`: driving high.
- `ST_PUMP_DN`: driving low.

Its transitions are:
- **lead-up**: FLOAT→UP on a signal event alone.
- **lead-down**: FLOAT→DN on a comparator event alone.
- **catch-up**: UP→FLOAT on any comparator event.
- **catch-down**: DN→FLOAT on any signal event.
- **repeat**: UP stays in UP, and DN stays in DN, when no releasing event arrives.
- **tie**: FLOAT stays in FLOAT when both events arrive in the same cycle.

Top module: `tri_state_pfd`

## Requirements
- R1: While `rst_n` is low at a clock edge, the outputs after that edge are `pump_oe`=0, `pump_drive`=0 and `phase_lock`=1, and the controller is in FLOAT.
- R2: From FLOAT, a signal rising edge with no comparator edge in the same cycle gives `pump_oe`=1 and `pump_drive`=1.
- R3: From FLOAT, a comparator rising edge with no signal edge in the same cycle gives `pump_oe`=1 and `pump_drive`=0.
- R4: In UP, a comparator rising edge releases the output (`pump_oe`=0). In DN, a signal rising edge releases it. While released, `pump_drive` is 0.
- R5: In UP, further signal rising edges keep the block in UP. In DN, further comparator rising edges keep it in DN.
- R6: `phase_lock` is 1 exactly when `pump_oe` is 0, in every cycle.
- R7: When the signal and comparator rising edges are detected in the same cycle, the block is in FLOAT afterwards, whether it started in FLOAT, UP or DN.
- R8: Falling edges and the time an input stays high have no effect: the outputs change only on rising edges.
- R9: With `SYNC_STAGES`=2, an input rising edge first sampled at clock edge k changes the outputs on edge k+3, and not before.
- R10: With no signal edges and a toggling comparator, after the first comparator edge the output stays driven low (`pump_oe`=1, `pump_drive`=0) in every cycle.
- R11: A signal pulse that is high for only one clock period counts as a full rising edge. From FLOAT it drives high until the next comparator edge.
- R12: When the comparator period is longer than the signal period, the block drives high in more cycles than it drives low. When the comparator period is shorter, it drives low in more cycles than it drives high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than either compared wave |
| rst_n | input | 1 | Active-low synchronous reset |
| sig_in | input | 1 | Asynchronous reference signal |
| cmp_in | input | 1 | Asynchronous feedback comparator signal |
| pump_drive | output | 1 | Value driven while enabled: 1 = high, 0 = low |
| pump_oe | output | 1 | Output enable for the charge output, active high |
| phase_lock | output | 1 | High while the charge output is released |

## Verification
The signal-edge event and the comparator-edge event can both be detected in the same clock cycle. The tie rule and the release rules then overlap. The bench provokes this in two ways. It raises both inputs on the same clock phase, once from FLOAT and once from UP. It also lets random toggling of both inputs produce coincident edges. In every cycle, a bench model of the requirement transitions computes the expected enable, drive value and lock flag. A coincident pair must leave the block in FLOAT without first passing through UP or DN.

// File: rtl/tspd_pkg.sv
package tspd_pkg;

    typedef enum logic [1:0] {
        ST_FLOAT   = 2'd0,
        ST_PUMP_UP = 2'd1,
        ST_PUMP_DN = 2'd2
    } tspd_state_t;

    localparam int unsigned TSPD_MIN_SYNC = 2;

endpackage

// File: rtl/tspd_edge_sync.sv
module tspd_edge_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise_o
);
    localparam int unsigned LAST = STAGES - 1;

    logic [STAGES-1:0] chain_q;
    logic              prev_q;
    logic              rise_q;

    // first synchronizer flop
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q[0] <= 1'b0;
        else        chain_q[0] <= async_in;
    end

    // remaining synchronizer flops
    for (genvar g = 1; g < STAGES; g++) begin : g_chain
        always_ff @(posedge clk) begin
            if (!rst_n) chain_q[g] <= 1'b0;
            else        chain_q[g] <= chain_q[g-1];
        end
    end

    // registered rising-edge detector: one-cycle event
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
            rise_q <= 1'b0;
        end else begin
            prev_q <= chain_q[LAST];
            rise_q <= chain_q[LAST] & ~prev_q;
        end
    end

    assign rise_o = rise_q;

endmodule

// File: rtl/tspd_ctrl.sv
module tspd_ctrl
    import tspd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sig_rise,
    input  logic cmp_rise,
    output logic drive_o,
    output logic oe_o,
    output logic lock_o
);
    tspd_state_t state_q;
    tspd_state_t state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_FLOAT: begin
                if (sig_rise && !cmp_rise)      state_d = ST_PUMP_UP; // lead-up
                else if (cmp_rise && !sig_rise) state_d = ST_PUMP_DN; // lead-down
                else                            state_d = ST_FLOAT;   // tie / idle
            end
            ST_PUMP_UP: begin
                if (cmp_rise) state_d = ST_FLOAT;                     // catch-up
                else          state_d = ST_PUMP_UP;                   // repeat
            end
            ST_PUMP_DN: begin
                if (sig_rise) state_d = ST_FLOAT;                     // catch-down
                else          state_d = ST_PUMP_DN;                   // repeat
            end
            default: state_d = ST_FLOAT;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_FLOAT;
        else        state_q <= state_d;
    end

    // registered outputs, decoded from the next state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            drive_o <= 1'b0;
            oe_o    <= 1'b0;
            lock_o  <= 1'b1;
        end else begin
            drive_o <= (state_d == ST_PUMP_UP);
            oe_o    <= (state_d != ST_FLOAT);
            lock_o  <= (state_d == ST_FLOAT);
        end
    end

endmodule

// File: rtl/tri_state_pfd.sv
module tri_state_pfd
    import tspd_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sig_in,
    input  logic cmp_in,
    output logic pump_drive,
    output logic pump_oe,
    output logic phase_lock
);
    localparam int unsigned N_IN = 2;
    localparam int unsigned DEPTH = (SYNC_STAGES < TSPD_MIN_SYNC) ? TSPD_MIN_SYNC : SYNC_STAGES;

    logic [N_IN-1:0] raw_in;
    logic [N_IN-1:0] rise;
    logic            sig_rise;
    logic            cmp_rise;

    assign raw_in = {cmp_in, sig_in};

    for (genvar i = 0; i < N_IN; i++) begin : g_in
        tspd_edge_sync #(.STAGES(DEPTH)) u_sync (
            .clk      (clk),
            .rst_n    (rst_n),
            .async_in (raw_in[i]),
            .rise_o   (rise[i])
        );
    end

    assign sig_rise = rise[0];
    assign cmp_rise = rise[1];

    tspd_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .sig_rise (sig_rise),
        .cmp_rise (cmp_rise),
        .drive_o  (pump_drive),
        .oe_o     (pump_oe),
        .lock_o   (phase_lock)
    );

endmodule

// File: rtl/tspd_checker.sv
module tspd_checker (
    input logic clk,
    input logic rst_n,
    input logic sig_rise,
    input logic cmp_rise,
    input logic pump_drive,
    input logic pump_oe,
    input logic phase_lock
);
    p_reset_state_r1: assert property (@(posedge clk)
        !rst_n |=> (!pump_oe && !pump_drive && phase_lock));

    p_lead_up_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (sig_rise && !cmp_rise && !pump_oe) |=> (pump_oe && pump_drive));

    p_lead_down_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_rise && !sig_rise && !pump_oe) |=> (pump_oe && !pump_drive));

    p_release_up_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (pump_oe && pump_drive && cmp_rise) |=> !pump_oe);

    p_release_dn_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (pump_oe && !pump_drive && sig_rise) |=> !pump_oe);

    p_quiet_drive_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !pump_oe |-> !pump_drive);

    p_hold_up_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pump_oe && pump_drive && !cmp_rise) |=> (pump_oe && pump_drive));

    p_hold_dn_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pump_oe && !pump_drive && !sig_rise) |=> (pump_oe && !pump_drive));

    p_lock_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
        phase_lock != pump_oe);

    p_tie_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (sig_rise && cmp_rise) |=> !pump_oe);

    p_no_event_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!sig_rise && !cmp_rise) |=> ($stable(pump_oe) && $stable(pump_drive)));

endmodule

bind tri_state_pfd tspd_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sig_rise   (sig_rise),
    .cmp_rise   (cmp_rise),
    .pump_drive (pump_drive),
    .pump_oe    (pump_oe),
    .phase_lock (phase_lock)
);

// File: tb/tri_state_pfd_bench.sv
module tri_state_pfd_bench;

    logic clk   = 1'b0;
    logic rst_n = 1'b0;
    logic sig_in = 1'b0;
    logic cmp_in = 1'b0;
    logic pump_drive;
    logic pump_oe;
    logic phase_lock;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;
    bit model_on = 1'b0;

    always #4 clk = ~clk; // 125 MHz

    tri_state_pfd u_tri_state_pfd (
        .clk        (clk),
        .rst_n      (rst_n),
        .sig_in     (sig_in),
        .cmp_in     (cmp_in),
        .pump_drive (pump_drive),
        .pump_oe    (pump_oe),
        .phase_lock (phase_lock)
    );

    // requirement model: 0 float, 1 up, 2 down; edge seen 3 edges after sampling (R9)
    logic [3:0] hs = 4'd0;
    logic [3:0] hc = 4'd0;
    logic [1:0] e_st = 2'd0;

    function automatic logic [1:0] next_st(input logic [1:0] st, input logic es, input logic ec);
        case (st)
            2'd0:    return (es && !ec) ? 2'd1 : ((ec && !es) ? 2'd2 : 2'd0);
            2'd1:    return ec ? 2'd0 : 2'd1;
            default: return es ? 2'd0 : 2'd2;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            hs   <= 4'd0;
            hc   <= 4'd0;
            e_st <= 2'd0;
        end else begin
            e_st <= next_st(e_st, hs[2] & ~hs[3], hc[2] & ~hc[3]);
            hs   <= {hs[2:0], sig_in};
            hc   <= {hc[2:0], cmp_in};
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the model (R2 R3 R4 R6 R7 R8)
    always @(negedge clk) begin
        if (model_on && rst_n) begin
            automatic int act = {29'd0, pump_oe, pump_drive, phase_lock};
            automatic int exp = {29'd0, e_st != 2'd0, e_st == 2'd1, e_st == 2'd0};
            chk(act == exp, (e_st == 2'd1) ? "R2" : ((e_st == 2'd2) ? "R3" : "R4"), act, exp);
            chk(phase_lock == !pump_oe, "R6", phase_lock, !pump_oe);
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic go_float();
        sig_in = 1'b0; cmp_in = 1'b0; cyc(4);
        if (pump_oe && pump_drive) begin cmp_in = 1'b1; cyc(6); cmp_in = 1'b0; cyc(4); end
        else if (pump_oe) begin sig_in = 1'b1; cyc(6); sig_in = 1'b0; cyc(4); end
    endtask

    initial begin
        void'($urandom(32'd1234));
        cyc(3);
        chk(!pump_oe && !pump_drive && phase_lock, "R1", {pump_oe, pump_drive, phase_lock}, 3'b001);
        rst_n = 1'b1;
        model_on = 1'b1;
        cyc(3);
        chk(!pump_oe && phase_lock, "R1", {pump_oe, phase_lock}, 2'b01);

        // R9 latency and R2 lead-up
        sig_in = 1'b1;
        cyc(3);
        chk(!pump_oe, "R9", pump_oe, 0);
        cyc(1);
        chk(pump_oe && pump_drive, "R9", {pump_oe, pump_drive}, 2'b11);
        // R8: falling edge and long high time change nothing
        cyc(10); sig_in = 1'b0; cyc(8);
        chk(pump_oe && pump_drive, "R8", {pump_oe, pump_drive}, 2'b11);
        // R5: more signal edges keep UP
        for (int k = 0; k < 3; k++) begin sig_in = 1'b1; cyc(3); sig_in = 1'b0; cyc(3); end
        chk(pump_oe && pump_drive, "R5", {pump_oe, pump_drive}, 2'b11);
        // R4 release by comparator
        cmp_in = 1'b1; cyc(4);
        chk(!pump_oe && !pump_drive, "R4", {pump_oe, pump_drive}, 2'b00);
        cmp_in = 1'b0; cyc(4);

        // R3 lead-down, R5 hold down, R4 release by signal
        cmp_in = 1'b1; cyc(4);
        chk(pump_oe && !pump_drive, "R3", {pump_oe, pump_drive}, 2'b10);
        cmp_in = 1'b0; cyc(3); cmp_in = 1'b1; cyc(4);
        chk(pump_oe && !pump_drive, "R5", {pump_oe, pump_drive}, 2'b10);
        sig_in = 1'b1; cyc(4);
        chk(!pump_oe, "R4", pump_oe, 0);
        go_float();

        // R7 tie from FLOAT
        sig_in = 1'b1; cmp_in = 1'b1; cyc(6);
        chk(!pump_oe && phase_lock, "R7", {pump_oe, phase_lock}, 2'b01);
        sig_in = 1'b0; cmp_in = 1'b0; cyc(4);
        // R7 tie from UP
        sig_in = 1'b1; cyc(5); sig_in = 1'b0; cyc(4);
        sig_in = 1'b1; cmp_in = 1'b1; cyc(3);
        chk(pump_oe && pump_drive, "R7", {pump_oe, pump_drive}, 2'b11);
        cyc(1);
        chk(!pump_oe, "R7", pump_oe, 0);
        sig_in = 1'b0; cmp_in = 1'b0; cyc(4);

        // R11 one-cycle spike
        sig_in = 1'b1; cyc(1); sig_in = 1'b0; cyc(20);
        chk(pump_oe && pump_drive, "R11", {pump_oe, pump_drive}, 2'b11);
        cmp_in = 1'b1; cyc(4); cmp_in = 1'b0;
        chk(!pump_oe, "R11", pump_oe, 0);
        cyc(4);

        // R10 comparator only
        begin
            automatic int low_cnt = 0;
            for (int t = 0; t < 240; t++) begin
                cmp_in = ((t % 6) < 3);
                @(negedge clk);
                if (t >= 8 && pump_oe && !pump_drive) low_cnt++;
            end
            chk(low_cnt == 232, "R10", low_cnt, 232);
        end
        cmp_in = 1'b0;
        go_float();

        // R12 frequency mismatch, both directions
        for (int dir = 0; dir < 2; dir++) begin
            automatic int up_c = 0;
            automatic int dn_c = 0;
            automatic int ps = (dir == 0) ? 8 : 11;
            automatic int pc = (dir == 0) ? 11 : 8;
            for (int t = 0; t < 880; t++) begin
                sig_in = ((t % ps) < ps / 2);
                cmp_in = ((t % pc) < pc / 2);
                @(negedge clk);
                if (pump_oe && pump_drive) up_c++;
                if (pump_oe && !pump_drive) dn_c++;
            end
            if (dir == 0) chk(up_c > dn_c, "R12", up_c, dn_c);
            else          chk(dn_c > up_c, "R12", dn_c, up_c);
            go_float();
        end

        // random phases and duty cycles, checked cycle by cycle against the model (R8)
        for (int t = 0; t < 6000; t++) begin
            if ($urandom_range(99) < 18) sig_in = ~sig_in;
            if ($urandom_range(99) < 18) cmp_in = ~cmp_in;
            if ($urandom_range(199) == 0) begin sig_in = 1'b1; cmp_in = 1'b1; end
            @(negedge clk);
        end

        // mid-run reset (R1)
        rst_n = 1'b0; cyc(1);
        chk(!pump_oe && !pump_drive && phase_lock, "R1", {pump_oe, pump_drive, phase_lock}, 3'b001);
        sig_in = 1'b0; cmp_in = 1'b0; cyc(2); rst_n = 1'b1; cyc(4);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule